// File: doc/BRIEF.md
# Cache and Bus Error Trap Router

This block receives error reports from an external cache and from a system bus, one report per channel per cycle. Each report names an error class and the operation that was under way when the error was seen. The router records every report in a sticky status register and, when the trap family that matches the class and operation is enabled, raises exactly one registered trap request pulse in the following cycle: a fast ECC trap, an instruction access error trap, a data access error trap or a disrupting ECC error trap.

Software controls the block through an enable register. Three of its bits gate the trap families. Two fields ask the external ECC encoder to substitute a forced check value on writes, one field for data and one for the memory tag. When two channels report in the same cycle, the report with the higher severity decides the trap. The status register keeps its bits until software writes ones to clear them, and it logs events even while their traps are disabled.

Top module: `errtrap_router`

## Requirements
- R1: Reset clears the enable register, the status register and all four trap outputs.
- R2: A write to the enable register stores the written value with bit 2 forced to zero; the stored value is readable on `cfg_rd` from the next cycle and takes effect on events from that cycle on.
- R3: Class 0 (software-correctable cache error) and class 1 (uncorrectable cache error) raise `trap_fast` one cycle later when enable bit 3 is set and the operation is 0 (load), 1 (instruction fetch) or 2 (atomic); operations 3 (store merge), 4 (writeback), 5 (copyout), 6 (vector fetch) and 7 (reserved) raise no trap for these classes.
- R4: Classes 2 (bus data uncorrectable), 3 (memory-tag uncorrectable), 4 (bus timeout) and 5 (bus error), with enable bit 1 set, raise `trap_iacc` for operation 1, `trap_dacc` for operations 0 and 2, `trap_disr` for operations 3, 4 and 5, and nothing for operation 7.
- R5: For classes 2 to 5 with operation 6 (vector fetch) and enable bit 1 set, the 2-bit hint selects the trap: 0 gives `trap_iacc`, 1 gives `trap_dacc`, 2 and 3 give `trap_disr`.
- R6: Classes 6 (hardware-corrected data) and 7 (hardware-corrected memory tag) raise `trap_disr` for any operation when enable bit 0 is set.
- R7: Every valid report sets status bit number equal to its class one cycle later, whether or not its trap is enabled; with the enable bit clear no trap is raised.
- R8: Writing ones through `sts_clr_mask` with `sts_clr_we` clears those status bits; a report arriving in the same cycle as the clear of its bit leaves the bit set.
- R9: At most one trap output is high in a cycle; a report of class 0 to 5 beats one of class 6 or 7, and between reports of equal severity channel 0 wins.
- R10: When enable bit 13 is set, `ecc_data_ovr_vld` is high and `ecc_data_ovr` carries enable bits 12:4; when enable bit 18 is set, `ecc_tag_ovr_vld` is high and `ecc_tag_ovr` carries bits 17:14; a field whose force bit is clear drives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_vld | input | NCH | Per-channel report strobe |
| ev_cls | input | NCH x 3 | Per-channel error class |
| ev_op | input | NCH x 3 | Per-channel operation type |
| ev_hint | input | NCH x 2 | Per-channel trap hint for vector fetches |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 19 | Enable register write value |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 8 | Status bits to clear |
| cfg_rd | output | 19 | Enable register contents |
| sts_rd | output | 8 | Sticky status register |
| trap_fast | output | 1 | Fast ECC trap request pulse |
| trap_iacc | output | 1 | Instruction access error trap pulse |
| trap_dacc | output | 1 | Data access error trap pulse |
| trap_disr | output | 1 | Disrupting ECC error trap pulse |
| ecc_data_ovr | output | 9 | Forced data check value |
| ecc_data_ovr_vld | output | 1 | Forced data check value valid |
| ecc_tag_ovr | output | 4 | Forced memory-tag check value |
| ecc_tag_ovr_vld | output | 1 | Forced memory-tag check value valid |

## Verification
Two coincidences matter: a status clear landing in the same cycle as a new report of that class, and reports on both channels in one cycle competing for the single trap output. The first is provoked by driving a clear mask together with a matching report, and is judged by the status bit staying set while other cleared bits drop. The second pairs corrected with uncorrected classes and equal-severity classes across channels, and a behavioural model in the bench predicts which single trap pulse appears.

// File: rtl/errtrap_pkg.sv
package errtrap_pkg;

    localparam int CLS_W  = 3;
    localparam int OP_W   = 3;
    localparam int HINT_W = 2;
    localparam int STS_W  = 1 << CLS_W;
    localparam int CFG_W  = 19;

    // enable register field positions
    localparam int EN_CE    = 0;
    localparam int EN_NC    = 1;
    localparam int CFG_RSVD = 2;
    localparam int EN_FAST  = 3;
    localparam int FD_LO    = 4;
    localparam int FD_W     = 9;
    localparam int FD_EN    = FD_LO + FD_W;
    localparam int FT_LO    = FD_EN + 1;
    localparam int FT_W     = 4;
    localparam int FT_EN    = FT_LO + FT_W;

    typedef enum logic [CLS_W-1:0] {
        CL_EC_SOFT = 3'd0,
        CL_EC_UNC  = 3'd1,
        CL_BUS_UE  = 3'd2,
        CL_TAG_UE  = 3'd3,
        CL_BUS_TO  = 3'd4,
        CL_BUS_ERR = 3'd5,
        CL_HW_DATA = 3'd6,
        CL_HW_TAG  = 3'd7
    } err_class_e;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD   = 3'd0,
        OP_IFETCH = 3'd1,
        OP_ATOMIC = 3'd2,
        OP_MERGE  = 3'd3,
        OP_WBACK  = 3'd4,
        OP_COPY   = 3'd5,
        OP_IVEC   = 3'd6,
        OP_RSVD   = 3'd7
    } err_op_e;

    typedef enum logic [2:0] {
        TK_NONE = 3'd0,
        TK_FAST = 3'd1,
        TK_IACC = 3'd2,
        TK_DACC = 3'd3,
        TK_DISR = 3'd4
    } trap_kind_e;

    typedef struct packed {
        trap_kind_e kind;
        logic       sev;
    } trap_req_t;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        trap_kind_e       trap;
    } rtr_state_t;

endpackage

// File: rtl/errtrap_cfg.sv
module errtrap_cfg
    import errtrap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [FD_W-1:0]  data_ovr,
    output logic             data_ovr_vld,
    output logic [FT_W-1:0]  tag_ovr,
    output logic             tag_ovr_vld
);

    localparam logic [CFG_W-1:0] ONE_BIT  = {{(CFG_W-1){1'b0}}, 1'b1};
    localparam logic [CFG_W-1:0] CFG_MASK = ~(ONE_BIT << CFG_RSVD);

    logic [CFG_W-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        data_ovr_vld = cfg_q[FD_EN];
        tag_ovr_vld  = cfg_q[FT_EN];
        data_ovr     = data_ovr_vld ? cfg_q[FD_LO +: FD_W] : '0;
        tag_ovr      = tag_ovr_vld  ? cfg_q[FT_LO +: FT_W] : '0;
    end

    // R10
    tag_ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_ovr_vld |-> (tag_ovr == '0));

endmodule

// File: rtl/errtrap_classify.sv
module errtrap_classify
    import errtrap_pkg::*;
(
    input  logic              vld,
    input  logic [CLS_W-1:0]  cls,
    input  logic [OP_W-1:0]   op,
    input  logic [HINT_W-1:0] hint,
    input  logic              en_ce,
    input  logic              en_nc,
    input  logic              en_fast,
    output trap_req_t         req,
    output logic [STS_W-1:0]  set_vec
);

    logic       local_read;
    trap_kind_e ue_kind;
    trap_kind_e hint_kind;

    always_comb begin
        local_read = (op == OP_LOAD) || (op == OP_IFETCH) || (op == OP_ATOMIC);
        case (hint)
            2'd0:    hint_kind = TK_IACC;
            2'd1:    hint_kind = TK_DACC;
            default: hint_kind = TK_DISR;
        endcase
        case (err_op_e'(op))
            OP_IFETCH:                  ue_kind = TK_IACC;
            OP_LOAD, OP_ATOMIC:         ue_kind = TK_DACC;
            OP_MERGE, OP_WBACK, OP_COPY: ue_kind = TK_DISR;
            OP_IVEC:                    ue_kind = hint_kind;
            default:                    ue_kind = TK_NONE;
        endcase
    end

    always_comb begin
        req.kind = TK_NONE;
        req.sev  = 1'b0;
        set_vec  = '0;
        if (vld) begin
            set_vec[cls] = 1'b1;
            case (err_class_e'(cls))
                CL_EC_SOFT, CL_EC_UNC: begin
                    if (en_fast && local_read) begin
                        req.kind = TK_FAST;
                        req.sev  = 1'b1;
                    end
                end
                CL_BUS_UE, CL_TAG_UE, CL_BUS_TO, CL_BUS_ERR: begin
                    if (en_nc && (ue_kind != TK_NONE)) begin
                        req.kind = ue_kind;
                        req.sev  = 1'b1;
                    end
                end
                default: begin
                    if (en_ce) begin
                        req.kind = TK_DISR;
                        req.sev  = 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/errtrap_arbiter.sv
module errtrap_arbiter
    import errtrap_pkg::*;
#(
    parameter int NCH = 2
) (
    input  trap_req_t  req [NCH],
    output trap_kind_e win
);

    logic best_sev;

    // walk from the highest channel down so that the lowest index
    // takes a tie of equal severity
    always_comb begin
        win      = TK_NONE;
        best_sev = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if ((req[i].kind != TK_NONE) &&
                ((win == TK_NONE) || (req[i].sev >= best_sev))) begin
                win      = req[i].kind;
                best_sev = req[i].sev;
            end
        end
    end

endmodule

// File: rtl/errtrap_router.sv
module errtrap_router
    import errtrap_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NCH-1:0]                 ev_vld,
    input  logic [NCH-1:0][CLS_W-1:0]      ev_cls,
    input  logic [NCH-1:0][OP_W-1:0]       ev_op,
    input  logic [NCH-1:0][HINT_W-1:0]     ev_hint,
    input  logic                           cfg_we,
    input  logic [CFG_W-1:0]               cfg_wdata,
    input  logic                           sts_clr_we,
    input  logic [STS_W-1:0]               sts_clr_mask,
    output logic [CFG_W-1:0]               cfg_rd,
    output logic [STS_W-1:0]               sts_rd,
    output logic                           trap_fast,
    output logic                           trap_iacc,
    output logic                           trap_dacc,
    output logic                           trap_disr,
    output logic [FD_W-1:0]                ecc_data_ovr,
    output logic                           ecc_data_ovr_vld,
    output logic [FT_W-1:0]                ecc_tag_ovr,
    output logic                           ecc_tag_ovr_vld
);

    rtr_state_t       st_d, st_q;
    trap_req_t        ch_req [NCH];
    logic [STS_W-1:0] ch_set [NCH];
    logic [STS_W-1:0] set_all;
    trap_kind_e       win_kind;

    errtrap_cfg i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .wdata        (cfg_wdata),
        .cfg_q        (cfg_rd),
        .data_ovr     (ecc_data_ovr),
        .data_ovr_vld (ecc_data_ovr_vld),
        .tag_ovr      (ecc_tag_ovr),
        .tag_ovr_vld  (ecc_tag_ovr_vld)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        errtrap_classify i_cls (
            .vld     (ev_vld[c]),
            .cls     (ev_cls[c]),
            .op      (ev_op[c]),
            .hint    (ev_hint[c]),
            .en_ce   (cfg_rd[EN_CE]),
            .en_nc   (cfg_rd[EN_NC]),
            .en_fast (cfg_rd[EN_FAST]),
            .req     (ch_req[c]),
            .set_vec (ch_set[c])
        );
    end

    errtrap_arbiter #(.NCH(NCH)) i_arb (
        .req (ch_req),
        .win (win_kind)
    );

    always_comb begin
        set_all = '0;
        for (int c = 0; c < NCH; c++) begin
            set_all = set_all | ch_set[c];
        end
    end

    always_comb begin
        st_d      = st_q;
        if (sts_clr_we) begin
            st_d.sts = st_q.sts & ~sts_clr_mask;
        end
        st_d.sts  = st_d.sts | set_all;
        st_d.trap = win_kind;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sts: '0, trap: TK_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_rd    = st_q.sts;
    assign trap_fast = (st_q.trap == TK_FAST);
    assign trap_iacc = (st_q.trap == TK_IACC);
    assign trap_dacc = (st_q.trap == TK_DACC);
    assign trap_disr = (st_q.trap == TK_DISR);

    // R3
    fast_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fast |-> $past(cfg_rd[EN_FAST]));

    // R4
    access_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_iacc || trap_dacc) |-> $past(cfg_rd[EN_NC]));

    // R6
    disr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_disr |-> $past(cfg_rd[EN_NC] || cfg_rd[EN_CE]));

    // R9
    no_spurious_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fast || trap_iacc || trap_dacc || trap_disr) |-> $past(|ev_vld));

    for (genvar i = 0; i < STS_W; i++) begin : g_sts_chk
        // R8
        sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sts_rd[i]) |-> $past(sts_clr_we && sts_clr_mask[i]));
        for (genvar c = 0; c < NCH; c++) begin : g_log
            // R7
            event_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_vld[c] && (ev_cls[c] == CLS_W'(i))) |=> sts_rd[i]);
        end
    end

endmodule

// File: tb/test_errtrap_router.sv
`timescale 1ns/1ps
module test_errtrap_router;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ev_vld;
    logic [1:0][2:0]  ev_cls;
    logic [1:0][2:0]  ev_op;
    logic [1:0][1:0]  ev_hint;
    logic             cfg_we;
    logic [18:0]      cfg_wdata;
    logic             sts_clr_we;
    logic [7:0]       sts_clr_mask;
    logic [18:0]      cfg_rd;
    logic [7:0]       sts_rd;
    logic             trap_fast, trap_iacc, trap_dacc, trap_disr;
    logic [8:0]       ecc_data_ovr;
    logic             ecc_data_ovr_vld;
    logic [3:0]       ecc_tag_ovr;
    logic             ecc_tag_ovr_vld;

    int n_total = 0;
    int n_fail  = 0;

    // reference model state
    logic [18:0] m_cfg;
    logic [7:0]  m_sts;
    int          m_trap;   // 0 none, 1 fast, 2 iacc, 3 dacc, 4 disr

    always #4 clk = ~clk;

    errtrap_router i_errtrap_router (
        .clk, .rst_n, .ev_vld, .ev_cls, .ev_op, .ev_hint,
        .cfg_we, .cfg_wdata, .sts_clr_we, .sts_clr_mask,
        .cfg_rd, .sts_rd, .trap_fast, .trap_iacc, .trap_dacc, .trap_disr,
        .ecc_data_ovr, .ecc_data_ovr_vld, .ecc_tag_ovr, .ecc_tag_ovr_vld
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_kind(input int cls, input int op, input int hint,
                                      input logic [18:0] cfg, output int sev);
        int k;
        k   = 0;
        sev = 0;
        if (cls <= 1) begin
            sev = 1;
            if (cfg[3] && op <= 2) k = 1;
        end else if (cls <= 5) begin
            sev = 1;
            if (cfg[1]) begin
                if (op == 1) k = 2;
                else if (op == 0 || op == 2) k = 3;
                else if (op >= 3 && op <= 5) k = 4;
                else if (op == 6) k = (hint == 0) ? 2 : (hint == 1) ? 3 : 4;
            end
        end else begin
            if (cfg[0]) k = 4;
        end
        if (k == 0) sev = 0;
        return k;
    endfunction

    function automatic string class_tag(input int cls, input int op);
        if (cls <= 1) return "R3";
        if (cls <= 5) return (op == 6) ? "R5" : "R4";
        return "R6";
    endfunction

    task automatic idle_inputs();
        ev_vld       = '0;
        ev_cls       = '0;
        ev_op        = '0;
        ev_hint      = '0;
        cfg_we       = 1'b0;
        cfg_wdata    = '0;
        sts_clr_we   = 1'b0;
        sts_clr_mask = '0;
    endtask

    task automatic compare_all(input string tag);
        int exp_tr;
        int exp_ovr;
        exp_tr = (m_trap == 1) ? 8 : (m_trap == 2) ? 4 : (m_trap == 3) ? 2 : (m_trap == 4) ? 1 : 0;
        exp_ovr = (m_cfg[13] ? (1 << 13) | (int'(m_cfg[12:4]) << 4) : 0)
                | (m_cfg[18] ? (1 << 4) | int'(m_cfg[17:14]) : 0);
        check(tag, "traps", int'({trap_fast, trap_iacc, trap_dacc, trap_disr}), exp_tr);
        check(tag, "status", int'(sts_rd), int'(m_sts));
        check(tag, "enable", int'(cfg_rd), int'(m_cfg));
        check(tag, "override",
              (ecc_data_ovr_vld << 13) | (int'(ecc_data_ovr) << 4) | (ecc_tag_ovr_vld << 4) | int'(ecc_tag_ovr),
              exp_ovr);
    endtask

    // one clock: predict from current inputs, advance, compare
    task automatic step(input string tag);
        logic [18:0] n_cfg;
        logic [7:0]  n_sts;
        int best, best_sev, k, s;
        n_cfg = cfg_we ? (cfg_wdata & 19'h7FFFB) : m_cfg;
        n_sts = sts_clr_we ? (m_sts & ~sts_clr_mask) : m_sts;
        best = 0;
        best_sev = -1;
        for (int c = 0; c < 2; c++) begin
            if (ev_vld[c]) begin
                n_sts[ev_cls[c]] = 1'b1;
                k = model_kind(int'(ev_cls[c]), int'(ev_op[c]), int'(ev_hint[c]), m_cfg, s);
                if (k != 0 && s > best_sev) begin
                    best = k;
                    best_sev = s;
                end
            end
        end
        @(posedge clk);
        #2;
        m_cfg  = n_cfg;
        m_sts  = n_sts;
        m_trap = best;
        compare_all(tag);
        idle_inputs();
    endtask

    task automatic write_cfg(input logic [18:0] v, input string tag);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step(tag);
    endtask

    task automatic clear_sts(input logic [7:0] m, input string tag);
        sts_clr_we = 1'b1;
        sts_clr_mask = m;
        step(tag);
    endtask

    task automatic event0(input int cls, input int op, input int hint, input string tag);
        ev_vld[0]  = 1'b1;
        ev_cls[0]  = 3'(cls);
        ev_op[0]   = 3'(op);
        ev_hint[0] = 2'(hint);
        step(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_total++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        idle_inputs();
        m_cfg = '0;
        m_sts = '0;
        m_trap = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        compare_all("R1");

        // R2: bit 2 reads back as zero; R10 both overrides live
        write_cfg(19'h7FFFF, "R2");
        step("R10");
        // R10: data forced to 0x0A5, tag value present but not forced
        write_cfg({1'b0, 4'h6, 1'b1, 9'h0A5, 4'h0}, "R10");
        write_cfg({1'b1, 4'h9, 1'b0, 9'h1C3, 4'h0}, "R10");

        // full sweep with every trap family enabled
        write_cfg(19'h0000B, "R2");
        for (int cls = 0; cls < 8; cls++) begin
            for (int op = 0; op < 8; op++) begin
                for (int h = 0; h < 4; h++) begin
                    event0(cls, op, h, class_tag(cls, op));
                end
            end
        end
        clear_sts(8'hFF, "R8");

        // R7: logging with traps disabled, no trap pulses
        write_cfg(19'h00000, "R7");
        for (int cls = 0; cls < 8; cls++) begin
            for (int op = 0; op < 8; op++) begin
                event0(cls, op, op & 3, "R7");
            end
        end
        clear_sts(8'hFF, "R8");

        // R9: coincident reports on both channels
        write_cfg(19'h0000B, "R2");
        ev_vld = 2'b11; ev_cls[0] = 3'd6; ev_op[0] = 3'd0; ev_cls[1] = 3'd2; ev_op[1] = 3'd0;
        step("R9");
        ev_vld = 2'b11; ev_cls[0] = 3'd2; ev_op[0] = 3'd1; ev_cls[1] = 3'd3; ev_op[1] = 3'd0;
        step("R9");
        ev_vld = 2'b11; ev_cls[0] = 3'd7; ev_op[0] = 3'd4; ev_cls[1] = 3'd6; ev_op[1] = 3'd1;
        step("R9");
        ev_vld = 2'b11; ev_cls[0] = 3'd0; ev_op[0] = 3'd3; ev_cls[1] = 3'd1; ev_op[1] = 3'd2;
        step("R9");
        ev_vld = 2'b10; ev_cls[1] = 3'd5; ev_op[1] = 3'd6; ev_hint[1] = 2'd1;
        step("R5");

        // R8: partial clear, then clear colliding with a new report
        clear_sts(8'h04, "R8");
        sts_clr_we = 1'b1; sts_clr_mask = 8'hC0;
        ev_vld[0] = 1'b1; ev_cls[0] = 3'd6; ev_op[0] = 3'd3;
        step("R8");
        clear_sts(8'hFF, "R8");
        step("R8");

        // R2: a write takes effect for events from the next cycle
        cfg_we = 1'b1; cfg_wdata = 19'h00000;
        ev_vld[0] = 1'b1; ev_cls[0] = 3'd1; ev_op[0] = 3'd0;
        step("R2");
        event0(1, 0, 0, "R2");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule